// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Occupancy Flags

This block is a 64-word, 36-bit first-in first-out buffer between two unrelated clock domains. The A side writes it on its own clock and the B side reads it on another. Each side sees only the status it needs, already in its own domain. The A side gets a full flag and an almost-full flag. The B side gets an empty flag and an almost-empty flag. Every flag is active low. Each side's pointer crosses to the other side as gray code through two flip-flops clocked by the receiving domain. Because of this delay, a flag that the far side has to clear clears a few cycles late, but it never clears early.

Each side has four qualifier pins: a chip select, a direction bit, an enable and a mailbox select. Together they form the side's transfer request. The request acts as a valid, and the side's own flag acts as its ready. A write is taken on an A-clock rising edge when the request is valid and `full_n` is high at that edge. A read is taken on a B-clock rising edge when the request is valid and `empty_n` is high at that edge. A request made while the flag is low is dropped, not held. The requester has to present it again on a later edge. Read data sits in an output register that changes only on a taken read.

One offset sets both almost flags. It is picked by a 2-bit select that each domain samples on its first clock edge after reset is released. Reset is active low and may be asserted and released at any time. It should be held for at least four rising edges of each clock.

Top module: `twoclk_fifo`

## Requirements
- R1: While `rst_n` is low, `full_n`=0, `empty_n`=0, `almost_empty_n`=0, `almost_full_n`=1 and `b_data`=0. Reset clears both pointers, so any words stored before it are discarded.
- R2: After `rst_n` rises, `full_n` stays low on the first A-clock rising edge and goes high on the second.
- R3: The almost-flag offset X is taken from `ofs_sel` at the first edge of each clock after reset release: 2'b00 gives 4, 2'b01 gives 8, 2'b10 gives 12, 2'b11 gives 16. Later changes of `ofs_sel` have no effect until the next reset.
- R4: A word is stored only when `a_cs_n`=0, `a_dir`=1, `a_en`=1, `a_mbox`=0 and `full_n`=1 at an A-clock edge. Under any other combination, nothing is stored and no flag changes.
- R5: A word is removed only when `b_cs_n`=0, `b_dir`=0, `b_en`=1, `b_mbox`=0 and `empty_n`=1 at a B-clock edge. Otherwise `b_data` holds its value and no flag changes.
- R6: Words leave in the order they were stored. `b_data` takes the removed word on the B-clock edge that removes it.
- R7: `full_n` goes low on the A-clock edge that stores the 64th word. It goes high again only after a removal has crossed into the A domain.
- R8: `empty_n` goes low on the B-clock edge that removes the last word. It goes high once a newly stored word has crossed into the B domain.
- R9: `almost_full_n` is low exactly when, in the A-domain view, X or fewer locations are free. It updates on the A-clock edge of the write that causes the change.
- R10: `almost_empty_n` is low exactly when, in the B-domain view, X or fewer words are stored. It updates on the B-clock edge of the read that causes the change.
- R11: The occupancy seen by either side never exceeds 64. Under any pattern of back-pressure, no word is lost or duplicated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_clk | input | 1 | Write-side clock |
| b_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ofs_sel | input | 2 | Almost-flag offset select, sampled after reset release |
| a_cs_n | input | 1 | Write-side select, active low |
| a_dir | input | 1 | Write-side direction, 1 = write |
| a_en | input | 1 | Write-side enable |
| a_mbox | input | 1 | Write-side mailbox select, must be 0 to reach the buffer |
| a_data | input | 36 | Word to store |
| full_n | output | 1 | Low when all 64 locations hold data (A domain) |
| almost_full_n | output | 1 | Low when X or fewer locations are free (A domain) |
| b_cs_n | input | 1 | Read-side select, active low |
| b_dir | input | 1 | Read-side direction, 0 = read |
| b_en | input | 1 | Read-side enable |
| b_mbox | input | 1 | Read-side mailbox select, must be 0 to reach the buffer |
| b_data | output | 36 | Registered output word |
| empty_n | output | 1 | Low when no word is stored (B domain) |
| almost_empty_n | output | 1 | Low when X or fewer words are stored (B domain) |

## Verification
A wrong pointer or a wrong occupancy count shows up at once as an almost flag out of place. The bench checks that flag against arithmetic on every single write and every single read, so the mistake is caught on the edge where it happens. A broken gray crossing or a badly qualified transfer is seen a few cycles later. It shows as a flag that never clears after the crossing delay, as a word out of order or repeated at `b_data`, or as a read count that differs from the write count. The sweep repeats the whole fill-and-drain sequence for all four offset selections. It changes the select after reset, so a latch that follows the pin shows up as a misplaced threshold.

// File: rtl/twoclk_fifo_pkg.sv
package twoclk_fifo_pkg;

  // Encoding of the almost-flag offset select pins.
  typedef enum logic [1:0] {
    OFS_4  = 2'b00,
    OFS_8  = 2'b01,
    OFS_12 = 2'b10,
    OFS_16 = 2'b11
  } ofs_sel_e;

  localparam int OFS_W = 5;

  // Offset in words for a given select code (R3).
  function automatic logic [OFS_W-1:0] ofs_words(input logic [1:0] sel);
    logic [OFS_W-1:0] w;
    case (ofs_sel_e'(sel))
      OFS_4:   w = 5'd4;
      OFS_8:   w = 5'd8;
      OFS_12:  w = 5'd12;
      default: w = 5'd16;
    endcase
    return w;
  endfunction

endpackage

// File: rtl/twoclk_ptr_cross.sv
// Carries a binary pointer into another clock domain: it is gray-encoded in
// a source-domain register, passed through two destination-domain flops,
// then decoded back to binary.
module twoclk_ptr_cross #(
  parameter int W = 7
) (
  input  logic         src_clk,
  input  logic         dst_clk,
  input  logic         rst_n,
  input  logic [W-1:0] src_bin,
  output logic [W-1:0] dst_bin
);

  logic [W-1:0] gray_q;
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge src_clk or negedge rst_n) begin
    if (!rst_n) gray_q <= '0;
    else        gray_q <= src_bin ^ (src_bin >> 1);
  end

  always_ff @(posedge dst_clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= gray_q;
      sync_q <= meta_q;
    end
  end

  always_comb begin
    for (int i = 0; i < W; i++) dst_bin[i] = ^(sync_q >> i);
  end

  // R11: the crossing code never moves more than one bit per source edge.
  p_gray_step_r11: assert property (@(posedge src_clk) disable iff (!rst_n)
    $countones(gray_q ^ $past(gray_q)) <= 1);

endmodule

// File: rtl/twoclk_wr_ctl.sv
// Write-side control: pointer, request qualification, full and almost-full.
module twoclk_wr_ctl
  import twoclk_fifo_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      ofs_sel,
  input  logic            cs_n,
  input  logic            dir,
  input  logic            en,
  input  logic            mbox,
  input  logic [ADDR_W:0] rptr_s,
  output logic            fire,
  output logic [ADDR_W:0] wptr,
  output logic            full_n,
  output logic            af_n
);

  localparam int              PTR_W   = ADDR_W + 1;
  localparam logic [PTR_W-1:0] DEPTH_P = PTR_W'(1) << ADDR_W;

  logic             live;
  logic [PTR_W-1:0] ofs_q;
  logic [PTR_W-1:0] wptr_nxt;
  logic [PTR_W-1:0] used_nxt;
  logic             full_nxt;
  logic             af_nxt;

  assign fire     = !cs_n && dir && en && !mbox && full_n;
  assign wptr_nxt = wptr + {{ADDR_W{1'b0}}, fire};
  assign used_nxt = wptr_nxt - rptr_s;
  assign full_nxt = (used_nxt == DEPTH_P);
  assign af_nxt   = ((DEPTH_P - used_nxt) <= ofs_q);

  // Offset follows the pins until the first edge after reset release.
  always_ff @(posedge clk) begin
    if (!live) ofs_q <= PTR_W'(ofs_words(ofs_sel));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live   <= 1'b0;
      wptr   <= '0;
      full_n <= 1'b0;
      af_n   <= 1'b1;
    end else begin
      live   <= 1'b1;
      wptr   <= wptr_nxt;
      full_n <= live && !full_nxt;
      af_n   <= !af_nxt;
    end
  end

  p_fill_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wptr - rptr_s) <= DEPTH_P);

  p_no_write_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !full_n |=> $stable(wptr));

  p_full_implies_af_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!full_n && live && $past(live)) |-> !af_n);

  p_ofs_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
    live |=> $stable(ofs_q));

endmodule

// File: rtl/twoclk_rd_ctl.sv
// Read-side control: pointer, request qualification, empty and almost-empty.
module twoclk_rd_ctl
  import twoclk_fifo_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      ofs_sel,
  input  logic            cs_n,
  input  logic            dir,
  input  logic            en,
  input  logic            mbox,
  input  logic [ADDR_W:0] wptr_s,
  output logic            fire,
  output logic [ADDR_W:0] rptr,
  output logic            empty_n,
  output logic            ae_n
);

  localparam int              PTR_W   = ADDR_W + 1;
  localparam logic [PTR_W-1:0] DEPTH_P = PTR_W'(1) << ADDR_W;

  logic             live;
  logic [PTR_W-1:0] ofs_q;
  logic [PTR_W-1:0] rptr_nxt;
  logic [PTR_W-1:0] stored_nxt;

  assign fire       = !cs_n && !dir && en && !mbox && empty_n;
  assign rptr_nxt   = rptr + {{ADDR_W{1'b0}}, fire};
  assign stored_nxt = wptr_s - rptr_nxt;

  always_ff @(posedge clk) begin
    if (!live) ofs_q <= PTR_W'(ofs_words(ofs_sel));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live    <= 1'b0;
      rptr    <= '0;
      empty_n <= 1'b0;
      ae_n    <= 1'b0;
    end else begin
      live    <= 1'b1;
      rptr    <= rptr_nxt;
      empty_n <= live && (stored_nxt != '0);
      ae_n    <= live && (stored_nxt > ofs_q);
    end
  end

  p_fill_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wptr_s - rptr) <= DEPTH_P);

  p_no_read_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !empty_n |=> $stable(rptr));

  p_empty_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!empty_n && $stable(wptr_s)) |=> !empty_n);

  p_empty_implies_ae_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !empty_n |-> !ae_n);

  p_ofs_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
    live |=> $stable(ofs_q));

endmodule

// File: rtl/twoclk_ram.sv
// Storage array: written on the A clock, read into a B-clock output register.
module twoclk_ram #(
  parameter int DATA_W = 36,
  parameter int ADDR_W = 6
) (
  input  logic              wclk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rclk,
  input  logic              rst_n,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n)  rdata <= '0;
    else if (re) rdata <= mem[raddr];
  end

  p_rd_hold_r5: assert property (@(posedge rclk) disable iff (!rst_n)
    !re |=> $stable(rdata));

endmodule

// File: rtl/twoclk_fifo.sv
module twoclk_fifo #(
  parameter int DATA_W = 36,
  parameter int ADDR_W = 6
) (
  input  logic              a_clk,
  input  logic              b_clk,
  input  logic              rst_n,
  input  logic [1:0]        ofs_sel,
  input  logic              a_cs_n,
  input  logic              a_dir,
  input  logic              a_en,
  input  logic              a_mbox,
  input  logic [DATA_W-1:0] a_data,
  output logic              full_n,
  output logic              almost_full_n,
  input  logic              b_cs_n,
  input  logic              b_dir,
  input  logic              b_en,
  input  logic              b_mbox,
  output logic [DATA_W-1:0] b_data,
  output logic              empty_n,
  output logic              almost_empty_n
);

  localparam int PTR_W = ADDR_W + 1;

  logic             wr_fire;
  logic             rd_fire;
  logic [PTR_W-1:0] wptr;
  logic [PTR_W-1:0] rptr;
  logic [PTR_W-1:0] wptr_in_b;
  logic [PTR_W-1:0] rptr_in_a;

  twoclk_ptr_cross #(.W(PTR_W)) u_w2b (
    .src_clk (a_clk),
    .dst_clk (b_clk),
    .rst_n   (rst_n),
    .src_bin (wptr),
    .dst_bin (wptr_in_b)
  );

  twoclk_ptr_cross #(.W(PTR_W)) u_r2a (
    .src_clk (b_clk),
    .dst_clk (a_clk),
    .rst_n   (rst_n),
    .src_bin (rptr),
    .dst_bin (rptr_in_a)
  );

  twoclk_wr_ctl #(.ADDR_W(ADDR_W)) u_wr (
    .clk     (a_clk),
    .rst_n   (rst_n),
    .ofs_sel (ofs_sel),
    .cs_n    (a_cs_n),
    .dir     (a_dir),
    .en      (a_en),
    .mbox    (a_mbox),
    .rptr_s  (rptr_in_a),
    .fire    (wr_fire),
    .wptr    (wptr),
    .full_n  (full_n),
    .af_n    (almost_full_n)
  );

  twoclk_rd_ctl #(.ADDR_W(ADDR_W)) u_rd (
    .clk     (b_clk),
    .rst_n   (rst_n),
    .ofs_sel (ofs_sel),
    .cs_n    (b_cs_n),
    .dir     (b_dir),
    .en      (b_en),
    .mbox    (b_mbox),
    .wptr_s  (wptr_in_b),
    .fire    (rd_fire),
    .rptr    (rptr),
    .empty_n (empty_n),
    .ae_n    (almost_empty_n)
  );

  twoclk_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
    .wclk  (a_clk),
    .we    (wr_fire),
    .waddr (wptr[ADDR_W-1:0]),
    .wdata (a_data),
    .rclk  (b_clk),
    .rst_n (rst_n),
    .re    (rd_fire),
    .raddr (rptr[ADDR_W-1:0]),
    .rdata (b_data)
  );

endmodule

// File: tb/twoclk_fifo_test.sv
module twoclk_fifo_test;

  logic        a_clk = 1'b0;
  logic        b_clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  ofs_sel = 2'b00;
  logic        a_cs_n = 1'b1, a_dir = 1'b0, a_en = 1'b0, a_mbox = 1'b0;
  logic [35:0] a_data = '0;
  logic        b_cs_n = 1'b1, b_dir = 1'b1, b_en = 1'b0, b_mbox = 1'b0;
  logic        full_n, almost_full_n, empty_n, almost_empty_n;
  logic [35:0] b_data;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  twoclk_fifo uut (
    .a_clk (a_clk), .b_clk (b_clk), .rst_n (rst_n), .ofs_sel (ofs_sel),
    .a_cs_n (a_cs_n), .a_dir (a_dir), .a_en (a_en), .a_mbox (a_mbox),
    .a_data (a_data), .full_n (full_n), .almost_full_n (almost_full_n),
    .b_cs_n (b_cs_n), .b_dir (b_dir), .b_en (b_en), .b_mbox (b_mbox),
    .b_data (b_data), .empty_n (empty_n), .almost_empty_n (almost_empty_n)
  );

  // 50 MHz on both sides, B side offset by 7 ns.
  initial forever #10 a_clk = ~a_clk;
  initial begin
    #7;
    forever #10 b_clk = ~b_clk;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [35:0] pat(input int s, input int k);
    logic [31:0] m;
    m = 32'(k) * 32'h9E3779B1;
    return {4'(s + 1), m};
  endfunction

  function automatic logic [35:0] spat(input int i);
    return {4'hC, 32'(i * 7919 + 3)};
  endfunction

  task automatic a_idle();
    a_cs_n = 1'b1; a_dir = 1'b0; a_en = 1'b0; a_mbox = 1'b0;
  endtask

  task automatic b_idle();
    b_cs_n = 1'b1; b_dir = 1'b1; b_en = 1'b0; b_mbox = 1'b0;
  endtask

  task automatic wr_cycle(input logic cs, input logic d, input logic e,
                          input logic mb, input logic [35:0] w);
    @(negedge a_clk);
    a_cs_n = cs; a_dir = d; a_en = e; a_mbox = mb; a_data = w;
    @(posedge a_clk);
    #1 a_idle();
  endtask

  task automatic rd_cycle(input logic cs, input logic d, input logic e,
                          input logic mb);
    @(negedge b_clk);
    b_cs_n = cs; b_dir = d; b_en = e; b_mbox = mb;
    @(posedge b_clk);
    #1 b_idle();
  endtask

  task automatic do_reset(input logic [1:0] s);
    a_idle();
    b_idle();
    rst_n = 1'b0;
    ofs_sel = s;
    repeat (5) @(posedge a_clk);
    repeat (5) @(posedge b_clk);
    #1;
    chk(full_n == 1'b0, "R1 full_n in reset", full_n, 0);
    chk(almost_full_n == 1'b1, "R1 almost_full_n in reset", almost_full_n, 1);
    chk(empty_n == 1'b0, "R1 empty_n in reset", empty_n, 0);
    chk(almost_empty_n == 1'b0, "R1 almost_empty_n in reset", almost_empty_n, 0);
    chk(b_data == '0, "R1 b_data in reset", b_data, 0);
    @(negedge a_clk);
    rst_n = 1'b1;
    @(posedge a_clk);
    #1 chk(full_n == 1'b0, "R2 full_n after first edge", full_n, 0);
    @(posedge a_clk);
    #1 chk(full_n == 1'b1, "R2 full_n after second edge", full_n, 1);
    repeat (3) @(posedge b_clk);
    #1 ofs_sel = ~s;  // R3: must be ignored from here on
  endtask

  initial begin
    a_idle();
    b_idle();
    for (int s = 0; s < 4; s++) begin
      int x;
      x = 4 * (s + 1);
      do_reset(2'(s));

      // R4: each disqualified write pattern stores nothing
      wr_cycle(1'b1, 1'b1, 1'b1, 1'b0, 36'h1);
      wr_cycle(1'b0, 1'b0, 1'b1, 1'b0, 36'h2);
      wr_cycle(1'b0, 1'b1, 1'b0, 1'b0, 36'h3);
      wr_cycle(1'b0, 1'b1, 1'b1, 1'b1, 36'h4);
      repeat (8) @(posedge b_clk);
      #1 chk(empty_n == 1'b0, "R4 ignored writes leave buffer empty", empty_n, 0);
      chk(almost_full_n == 1'b1, "R4 ignored writes leave almost_full_n", almost_full_n, 1);

      // R9 / R7: fill, checking flags on every write edge
      for (int k = 1; k <= 64; k++) begin
        wr_cycle(1'b0, 1'b1, 1'b1, 1'b0, pat(s, k));
        chk(almost_full_n == !(k >= 64 - x), "R9 almost_full_n during fill",
            almost_full_n, !(k >= 64 - x));
        chk(full_n == (k < 64), "R7 full_n during fill", full_n, (k < 64));
      end
      wr_cycle(1'b0, 1'b1, 1'b1, 1'b0, 36'hF_FFFF_FFFF);
      chk(full_n == 1'b0, "R4 write while full keeps full_n low", full_n, 0);

      repeat (8) @(posedge b_clk);
      #1 chk(empty_n == 1'b1, "R8 empty_n high once writes cross", empty_n, 1);
      chk(almost_empty_n == 1'b1, "R10 almost_empty_n high when full", almost_empty_n, 1);

      // R5: disqualified reads leave output and flags alone
      rd_cycle(1'b1, 1'b0, 1'b1, 1'b0);
      rd_cycle(1'b0, 1'b1, 1'b1, 1'b0);
      rd_cycle(1'b0, 1'b0, 1'b0, 1'b0);
      rd_cycle(1'b0, 1'b0, 1'b1, 1'b1);
      chk(b_data == '0, "R5 ignored reads hold b_data", b_data, 0);
      chk(almost_empty_n == 1'b1, "R5 ignored reads hold almost_empty_n", almost_empty_n, 1);

      // R6 / R10 / R8: drain
      for (int j = 1; j <= 64; j++) begin
        rd_cycle(1'b0, 1'b0, 1'b1, 1'b0);
        chk(b_data == pat(s, j), "R6 read order", b_data, pat(s, j));
        chk(almost_empty_n == !((64 - j) <= x), "R10 almost_empty_n during drain",
            almost_empty_n, !((64 - j) <= x));
        chk(empty_n == (j < 64), "R8 empty_n during drain", empty_n, (j < 64));
      end
      rd_cycle(1'b0, 1'b0, 1'b1, 1'b0);
      chk(b_data == pat(s, 64), "R5 read while empty holds b_data", b_data, pat(s, 64));
      chk(empty_n == 1'b0, "R4 extra write was not stored", empty_n, 0);

      repeat (8) @(posedge a_clk);
      #1 chk(full_n == 1'b1, "R7 full_n high once reads cross", full_n, 1);
      chk(almost_full_n == 1'b1, "R3 almost_full_n after drain", almost_full_n, 1);
    end

    // R6 / R11: concurrent streaming with back-pressure on both sides
    do_reset(2'b00);
    begin
      int wcount;
      int rcount;
      wcount = 0;
      rcount = 0;
      fork
        begin
          while (wcount < 200) begin
            @(negedge a_clk);
            if (full_n) begin
              a_cs_n = 1'b0; a_dir = 1'b1; a_en = 1'b1; a_mbox = 1'b0;
              a_data = spat(wcount);
              wcount++;
            end else begin
              a_en = 1'b0;
            end
          end
          @(negedge a_clk);
          a_idle();
        end
        begin
          int cyc;
          cyc = 0;
          while (rcount < 200) begin
            @(negedge b_clk);
            cyc++;
            if (empty_n && (rcount >= 120 || cyc % 3 == 0)) begin
              b_cs_n = 1'b0; b_dir = 1'b0; b_en = 1'b1; b_mbox = 1'b0;
              @(posedge b_clk);
              #1 chk(b_data == spat(rcount), "R6 streamed word order", b_data, spat(rcount));
              rcount++;
            end else begin
              b_en = 1'b0;
            end
          end
          b_idle();
        end
      join
      repeat (8) @(posedge b_clk);
      #1 chk(empty_n == 1'b0, "R11 no extra words after stream", empty_n, 0);
      repeat (8) @(posedge a_clk);
      #1 chk(full_n == 1'b1, "R11 full_n released after stream", full_n, 1);
    end

    // R1: reset discards stored words
    for (int k = 0; k < 10; k++) wr_cycle(1'b0, 1'b1, 1'b1, 1'b0, pat(7, k));
    repeat (8) @(posedge b_clk);
    #1 chk(empty_n == 1'b1, "R1 words present before reset", empty_n, 1);
    do_reset(2'b01);
    repeat (8) @(posedge b_clk);
    #1 chk(empty_n == 1'b0, "R1 buffer empty after reset", empty_n, 0);
    chk(almost_empty_n == 1'b0, "R1 almost_empty_n after reset", almost_empty_n, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge a_clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule